// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block turns one cache maintenance request into the ordered series of commands a downstream cache controller executes. A request names an operation (invalidate, clean, or flush, meaning clean then invalidate), a byte start address and an exclusive byte end address. The block issues single-line clean-and-invalidate commands for partly covered edge lines of an invalidate. It issues range commands over whole lines, each carrying an inclusive first-line and last-line address.

Each range command covers a chunk of the request. A chunk stops at the request end, at the next page start, or after a fixed byte budget, whichever comes first. A static write-through override input removes clean work, because a write-through cache never holds dirty lines. Commands leave one at a time on a valid/ready handshake. A one-cycle done pulse closes the request, and the block then accepts the next one.

Top module: `cache_range_seq`

## Requirements
- R1: Operation codes on `req_op` are 0 invalidate, 1 clean, 2 flush. Command kinds on `cmd_kind` are 0 single-line clean-and-invalidate, 1 range clean, 2 range invalidate. For an invalidate whose start is not line aligned (32-byte lines), the first command is a kind-0 command on the line that holds the start byte. The start is then rounded up to the next line boundary.
- R2: For an invalidate whose end is not line aligned, a kind-0 command is issued on the line holding the end byte, provided the rounded-up start is below the end. It follows any R1 command and precedes all range commands. The end is then rounded down to a line boundary.
- R3: Clean and flush requests round the start down and the end up to line boundaries and issue no kind-0 commands. Every command address is line aligned.
- R4: A range command's `cmd_addr` is its chunk's first line. `cmd_last` is the chunk end minus 32. No chunk spans more than MAX_CHUNK_BYTES (default 1024). Successive chunks are contiguous and in ascending order.
- R5: A range command never spans two pages (PAGE_BYTES, default 4096). A chunk is cut at `(start | (PAGE_BYTES-1)) + 1`.
- R6: A flush with the override low emits, for every chunk, a range clean followed by a range invalidate over the same two addresses.
- R7: With `wt_override` high, a clean emits no commands and a flush emits only range invalidates. An invalidate is unaffected.
- R8: When the rounded start is not below the rounded end, no range command is emitted, and the done pulse still follows.
- R9: A request is taken only while `req_ready` is high, which is only when idle. `req_valid` and request fields presented while busy have no effect.
- R10: `done` is high for exactly one cycle. It comes in the cycle after the last command handshake, or in the cycle after acceptance when the request emits no command.
- R11: While `cmd_valid` is high and `cmd_ready` low, the command fields and `cmd_valid` hold steady.
- R12: Operation code 3 behaves exactly as flush.
- R13: Reset, synchronous and active high, leaves the block idle: `req_ready` high, `cmd_valid` and `done` low. It aborts any request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_op | input | 2 | Operation code (R1, R12) |
| req_start | input | ADDR_W | First byte address |
| req_end | input | ADDR_W | Exclusive end byte address |
| wt_override | input | 1 | Write-through override, held static |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Controller accepts command |
| cmd_kind | output | 2 | Command kind (R1) |
| cmd_addr | output | ADDR_W | Line address, or first line of a range |
| cmd_last | output | ADDR_W | Last line of a range, equal to cmd_addr for line commands |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The first command is due on the clock edge that accepts the request. Every following command, or the done pulse, is due on the edge that completes the previous handshake, with no idle cycle between them. Inputs change on the falling edge. At each falling edge the bench logs a command only when valid and ready are both high. It then requires `done` at the next falling edge after the last logged handshake, or after acceptance for an empty request. One falling edge later it requires `done` low and `req_ready` high. Under alternating ready, the fields seen during a stalled cycle are compared with those seen at the next falling edge.

// File: rtl/cache_seq_pkg.sv
package cache_seq_pkg;

  typedef enum logic [1:0] {
    MOP_INV    = 2'd0,
    MOP_CLEAN  = 2'd1,
    MOP_FLUSH  = 2'd2,
    MOP_FLUSH2 = 2'd3
  } maint_op_e;

  typedef enum logic [1:0] {
    CK_LINE_CLNINV = 2'd0,
    CK_RANGE_CLEAN = 2'd1,
    CK_RANGE_INV   = 2'd2
  } cmd_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HEAD,
    SQ_TAIL,
    SQ_RCLEAN,
    SQ_RINV,
    SQ_DONE
  } seq_state_e;

endpackage

// File: rtl/cache_req_align.sv
module cache_req_align
  import cache_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  maint_op_e           op,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [ADDR_W-1:0]   end_addr,
  output logic                head_need,
  output logic [ADDR_W-1:0]   head_addr,
  output logic                tail_need,
  output logic [ADDR_W-1:0]   tail_addr,
  output logic [ADDR_W-1:0]   first_addr,
  output logic [ADDR_W-1:0]   limit_addr
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

  logic [ADDR_W-1:0] start_dn, start_up, end_dn, end_up;
  logic              start_part, end_part, is_inv;

  always_comb begin
    is_inv     = (op == MOP_INV);
    start_part = |(start_addr & LINE_MASK);
    end_part   = |(end_addr & LINE_MASK);
    start_dn   = start_addr & ~LINE_MASK;
    end_dn     = end_addr & ~LINE_MASK;
    start_up   = start_part ? start_dn + LINE_STEP : start_dn;
    end_up     = end_part ? end_dn + LINE_STEP : end_dn;

    head_need  = is_inv && start_part;
    head_addr  = start_dn;
    tail_need  = is_inv && end_part && (start_up < end_addr);
    tail_addr  = end_dn;
    first_addr = is_inv ? start_up : start_dn;
    limit_addr = is_inv ? end_dn : end_up;
  end
endmodule

// File: rtl/cache_chunk_bound.sv
module cache_chunk_bound #(
  parameter int ADDR_W          = 32,
  parameter int LINE_BYTES      = 32,
  parameter int MAX_CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES      = 4096
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] limit_addr,
  output logic [ADDR_W-1:0] chunk_end,
  output logic [ADDR_W-1:0] chunk_last
);
  localparam int XW = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

  logic [XW-1:0] budget_x, page_x, lim_x;
  logic          use_budget, use_page;

  always_comb begin
    budget_x   = {1'b0, cur_addr} + XW'(MAX_CHUNK_BYTES);
    page_x     = {1'b0, cur_addr | PAGE_MASK} + XW'(1);
    lim_x      = {1'b0, limit_addr};
    use_page   = (page_x < lim_x) && (page_x < budget_x);
    use_budget = (budget_x < lim_x) && (budget_x <= page_x);
    if (use_page)        chunk_end = page_x[ADDR_W-1:0];
    else if (use_budget) chunk_end = budget_x[ADDR_W-1:0];
    else                 chunk_end = limit_addr;
    chunk_last = chunk_end - LINE_STEP;
  end
endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
  import cache_seq_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int LINE_BYTES      = 32,
  parameter int MAX_CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES      = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic              wt_override,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_last,
  output logic              done
);
  seq_state_e        state_q, state_n;
  maint_op_e         op_q, op_n;
  logic              wt_q, wt_n;
  logic              head_q, head_n, tail_q, tail_n;
  logic [ADDR_W-1:0] head_addr_q, head_addr_n, tail_addr_q, tail_addr_n;
  logic [ADDR_W-1:0] cur_q, cur_n, limit_q, limit_n, chunk_end_q, chunk_end_n;
  cmd_kind_e         kind_q, kind_n;
  logic [ADDR_W-1:0] addr_q, addr_n, last_q, last_n;

  logic              al_head, al_tail;
  logic [ADDR_W-1:0] al_head_addr, al_tail_addr, al_first, al_limit;
  logic [ADDR_W-1:0] cb_end, cb_last;
  logic              fire_cmd, pick, go_inv, want_clean;

  cache_req_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .op         (maint_op_e'(req_op)),
    .start_addr (req_start),
    .end_addr   (req_end),
    .head_need  (al_head),
    .head_addr  (al_head_addr),
    .tail_need  (al_tail),
    .tail_addr  (al_tail_addr),
    .first_addr (al_first),
    .limit_addr (al_limit)
  );

  cache_chunk_bound #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .MAX_CHUNK_BYTES(MAX_CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_chunk (
    .cur_addr   (cur_n),
    .limit_addr (limit_n),
    .chunk_end  (cb_end),
    .chunk_last (cb_last)
  );

  assign cmd_valid = (state_q == SQ_HEAD) || (state_q == SQ_TAIL) ||
                     (state_q == SQ_RCLEAN) || (state_q == SQ_RINV);
  assign fire_cmd  = cmd_valid && cmd_ready;
  assign req_ready = (state_q == SQ_IDLE);
  assign done      = (state_q == SQ_DONE);
  assign cmd_kind  = kind_q;
  assign cmd_addr  = addr_q;
  assign cmd_last  = last_q;

  // Bookkeeping update after a request is taken or a command is accepted.
  always_comb begin
    op_n        = op_q;
    wt_n        = wt_q;
    head_n      = head_q;
    tail_n      = tail_q;
    head_addr_n = head_addr_q;
    tail_addr_n = tail_addr_q;
    cur_n       = cur_q;
    limit_n     = limit_q;
    pick        = 1'b0;
    go_inv      = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (req_valid) begin
        op_n        = maint_op_e'(req_op);
        wt_n        = wt_override;
        head_n      = al_head;
        tail_n      = al_tail;
        head_addr_n = al_head_addr;
        tail_addr_n = al_tail_addr;
        cur_n       = al_first;
        limit_n     = al_limit;
        pick        = 1'b1;
      end
      SQ_HEAD: if (fire_cmd) begin
        head_n = 1'b0;
        pick   = 1'b1;
      end
      SQ_TAIL: if (fire_cmd) begin
        tail_n = 1'b0;
        pick   = 1'b1;
      end
      SQ_RCLEAN: if (fire_cmd) begin
        if (op_q[1]) begin
          go_inv = 1'b1;
        end else begin
          cur_n = chunk_end_q;
          pick  = 1'b1;
        end
      end
      SQ_RINV: if (fire_cmd) begin
        cur_n = chunk_end_q;
        pick  = 1'b1;
      end
      default: ;
    endcase
  end

  // Choice of the next command to present, or completion.
  always_comb begin
    state_n     = state_q;
    kind_n      = kind_q;
    addr_n      = addr_q;
    last_n      = last_q;
    chunk_end_n = chunk_end_q;
    want_clean  = (op_n == MOP_CLEAN) || (op_n[1] && !wt_n);
    if (state_q == SQ_DONE) state_n = SQ_IDLE;
    if (go_inv) begin
      state_n = SQ_RINV;
      kind_n  = CK_RANGE_INV;
    end else if (pick) begin
      if (head_n) begin
        state_n = SQ_HEAD;
        kind_n  = CK_LINE_CLNINV;
        addr_n  = head_addr_n;
        last_n  = head_addr_n;
      end else if (tail_n) begin
        state_n = SQ_TAIL;
        kind_n  = CK_LINE_CLNINV;
        addr_n  = tail_addr_n;
        last_n  = tail_addr_n;
      end else if ((cur_n < limit_n) && !((op_n == MOP_CLEAN) && wt_n)) begin
        state_n     = want_clean ? SQ_RCLEAN : SQ_RINV;
        kind_n      = want_clean ? CK_RANGE_CLEAN : CK_RANGE_INV;
        addr_n      = cur_n;
        last_n      = cb_last;
        chunk_end_n = cb_end;
      end else begin
        state_n = SQ_DONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      op_q        <= MOP_INV;
      wt_q        <= 1'b0;
      head_q      <= 1'b0;
      tail_q      <= 1'b0;
      head_addr_q <= '0;
      tail_addr_q <= '0;
      cur_q       <= '0;
      limit_q     <= '0;
      chunk_end_q <= '0;
      kind_q      <= CK_LINE_CLNINV;
      addr_q      <= '0;
      last_q      <= '0;
    end else begin
      state_q     <= state_n;
      op_q        <= op_n;
      wt_q        <= wt_n;
      head_q      <= head_n;
      tail_q      <= tail_n;
      head_addr_q <= head_addr_n;
      tail_addr_q <= tail_addr_n;
      cur_q       <= cur_n;
      limit_q     <= limit_n;
      chunk_end_q <= chunk_end_n;
      kind_q      <= kind_n;
      addr_q      <= addr_n;
      last_q      <= last_n;
    end
  end
endmodule

// File: rtl/cache_range_seq_chk.sv
module cache_range_seq_chk #(
  parameter int ADDR_W          = 32,
  parameter int LINE_BYTES      = 32,
  parameter int MAX_CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES      = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wt_override,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [ADDR_W-1:0] cmd_last,
  input logic              done
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] SPAN_MAX = ADDR_W'(MAX_CHUNK_BYTES - LINE_BYTES);

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) &&
                                   $stable(cmd_addr) && $stable(cmd_last)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_fire_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past((cmd_valid && cmd_ready) || (req_valid && req_ready)));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid || done) |-> !req_ready);

  assert_line_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_addr[LINE_LSB-1:0] == '0 && cmd_last[LINE_LSB-1:0] == '0));

  assert_chunk_span_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind != 2'd0) |->
      (cmd_last >= cmd_addr && (cmd_last - cmd_addr) <= SPAN_MAX));

  assert_same_page_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind != 2'd0) |->
      (cmd_addr[ADDR_W-1:PAGE_LSB] == cmd_last[ADDR_W-1:PAGE_LSB]));

  assert_no_clean_wt_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'd1) |-> !wt_override);

  assert_reset_idle_R13: assert property (@(posedge clk)
    rst |=> (req_ready && !cmd_valid && !done));
endmodule

bind cache_range_seq cache_range_seq_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .MAX_CHUNK_BYTES(MAX_CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .wt_override(wt_override), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_last(cmd_last), .done(done)
);

// File: tb/cache_range_seq_bench.sv
module cache_range_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [1:0]  op;
    logic        wt;
    logic [31:0] s;
    logic [31:0] e;
    logic [7:0]  cnt;
    logic [1:0]  fk;
    logic [31:0] fa;
    logic [31:0] fl;
    logic [1:0]  lk;
    logic [31:0] la;
    logic [31:0] ll;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 32'h1010, 32'h1050, 8'd3, 2'd0, 32'h1000, 32'h1000, 2'd2, 32'h1020, 32'h1020},
    '{2'd0, 1'b0, 32'h2008, 32'h2010, 8'd1, 2'd0, 32'h2000, 32'h2000, 2'd0, 32'h2000, 32'h2000},
    '{2'd1, 1'b0, 32'h0000, 32'h0900, 8'd3, 2'd1, 32'h0000, 32'h03E0, 2'd1, 32'h0800, 32'h08E0},
    '{2'd1, 1'b1, 32'h0000, 32'h0900, 8'd0, 2'd0, 32'h0,    32'h0,    2'd0, 32'h0,    32'h0},
    '{2'd2, 1'b0, 32'h0F10, 32'h1105, 8'd4, 2'd1, 32'h0F00, 32'h0FE0, 2'd2, 32'h1000, 32'h1100},
    '{2'd2, 1'b1, 32'h0F10, 32'h1105, 8'd2, 2'd2, 32'h0F00, 32'h0FE0, 2'd2, 32'h1000, 32'h1100},
    '{2'd0, 1'b1, 32'h3000, 32'h3800, 8'd2, 2'd2, 32'h3000, 32'h33E0, 2'd2, 32'h3400, 32'h37E0},
    '{2'd1, 1'b0, 32'h0500, 32'h0500, 8'd0, 2'd0, 32'h0,    32'h0,    2'd0, 32'h0,    32'h0},
    '{2'd3, 1'b0, 32'h0040, 32'h0060, 8'd2, 2'd1, 32'h0040, 32'h0040, 2'd2, 32'h0040, 32'h0040},
    '{2'd0, 1'b0, 32'h7FE4, 32'h8008, 8'd2, 2'd0, 32'h7FE0, 32'h7FE0, 2'd0, 32'h8000, 32'h8000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_start = '0;
  logic [31:0] req_end = '0;
  logic        wt_override = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_kind;
  logic [31:0] cmd_addr;
  logic [31:0] cmd_last;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tags [NVEC];

  cache_range_seq u_cache_range_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_start(req_start), .req_end(req_end),
    .wt_override(wt_override), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_last(cmd_last), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d", cycles, 50000);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic wt,
                         input logic [31:0] s, input logic [31:0] e,
                         input int rmode, input bit poke,
                         output int n, output logic [1:0] fk, output logic [1:0] lk,
                         output logic [31:0] fa, output logic [31:0] fl,
                         output logic [31:0] la, output logic [31:0] ll,
                         output bit done_ok);
    bit prev_evt;
    bit held;
    logic [1:0] hk;
    logic [31:0] ha, hl;
    int cyc;
    @(negedge clk);
    req_op = op; req_start = s; req_end = e; wt_override = wt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; fk = '0; lk = '0; fa = '0; fl = '0; la = '0; ll = '0;
    prev_evt = 1'b1; done_ok = 1'b0; held = 1'b0; cyc = 0;
    hk = '0; ha = '0; hl = '0;
    while (cyc < 400) begin
      if (done) begin
        done_ok = prev_evt;
        break;
      end
      if (held) begin
        chk("R11 stalled command held", {cmd_valid, cmd_kind, cmd_addr, cmd_last[28:0]},
            {1'b1, hk, ha, hl[28:0]});
        held = 1'b0;
      end
      if (poke && cyc == 1) begin
        req_valid = 1'b1; req_op = 2'd0; req_start = 32'h9000; req_end = 32'hA000;
      end
      if (poke && cyc == 3) req_valid = 1'b0;
      cmd_ready = (rmode == 0) || cyc[0];
      prev_evt = cmd_valid && cmd_ready;
      if (cmd_valid && !cmd_ready) begin
        held = 1'b1; hk = cmd_kind; ha = cmd_addr; hl = cmd_last;
      end
      if (prev_evt) begin
        if (n == 0) begin fk = cmd_kind; fa = cmd_addr; fl = cmd_last; end
        lk = cmd_kind; la = cmd_addr; ll = cmd_last;
        n = n + 1;
      end
      @(negedge clk);
      cyc = cyc + 1;
    end
    cmd_ready = 1'b0;
  endtask

  initial begin
    int n;
    logic [1:0] fk, lk;
    logic [31:0] fa, fl, la, ll;
    bit dok;
    tags[0] = "R1 R2 inv both edges";
    tags[1] = "R2 R8 inv tiny, no tail";
    tags[2] = "R4 clean budget split";
    tags[3] = "R7 clean with override";
    tags[4] = "R5 R6 flush page cut";
    tags[5] = "R7 flush with override";
    tags[6] = "R4 R7 inv aligned, override ignored";
    tags[7] = "R8 empty clean";
    tags[8] = "R12 op3 as flush";
    tags[9] = "R1 R2 inv across page";

    repeat (3) @(negedge clk);
    chk("R13 reset req_ready", {63'd0, req_ready}, 64'd1);
    chk("R13 reset cmd_valid", {63'd0, cmd_valid}, 64'd0);
    chk("R13 reset done", {63'd0, done}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      run_req(VECS[i].op, VECS[i].wt, VECS[i].s, VECS[i].e, i % 2, 1'b0,
              n, fk, lk, fa, fl, la, ll, dok);
      chk({tags[i], " count"}, 64'(n), 64'(VECS[i].cnt));
      if (VECS[i].cnt != 0) begin
        chk({tags[i], " first kind/addr"}, {30'd0, fk, fa}, {30'd0, VECS[i].fk, VECS[i].fa});
        chk({tags[i], " first last"}, {32'd0, fl}, {32'd0, VECS[i].fl});
        chk({tags[i], " final kind/addr"}, {30'd0, lk, la}, {30'd0, VECS[i].lk, VECS[i].la});
        chk({tags[i], " final last"}, {32'd0, ll}, {32'd0, VECS[i].ll});
      end
      chk({tags[i], " R10 done timing"}, {63'd0, dok}, 64'd1);
      @(negedge clk);
      chk({tags[i], " R10 done one cycle"}, {62'd0, done, req_ready}, 64'd1);
    end

    // R9: a request presented while busy is ignored.
    run_req(2'd1, 1'b0, 32'h0, 32'h0900, 1, 1'b1, n, fk, lk, fa, fl, la, ll, dok);
    chk("R9 busy request ignored, count", 64'(n), 64'd3);
    chk("R9 busy request ignored, final addr", {32'd0, la}, {32'd0, 32'h0800});
    chk("R9 busy request ignored, done", {63'd0, dok}, 64'd1);
    repeat (3) @(negedge clk);
    chk("R9 nothing latched while busy", {62'd0, cmd_valid, req_ready}, 64'd1);

    // R13: reset aborts a request in progress.
    req_op = 2'd2; req_start = 32'h0F10; req_end = 32'h1105; wt_override = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 busy before reset", {63'd0, cmd_valid}, 64'd1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 aborted to idle", {61'd0, req_ready, cmd_valid, done}, 64'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule